// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital sequencer that runs a successive-approximation converter with a multiplexed input. It picks the input channel for each conversion, starts the converter with a one-cycle start pulse, and waits for the converter's done pulse. It formats the returned sample to the programmed resolution and stores it, together with its channel number, in a result register. Conversions run on one fixed channel or walk down through a group of channels, and either kind runs once or repeats.

The input set has twelve channels, numbered 0 to 7 and 12 to 15. Numbers 8 to 11 have no input behind them, so a group walk steps from 12 straight to 7. An optional hold mode waits until software has read the previous result before it starts the next normal conversion. A hardware trigger can request an extra conversion of a separately programmed channel. That conversion goes ahead of the next group channel, its result goes to its own register, and the group walk then picks up where it stopped. Normal completions, injected completions and overwrite errors each pulse their own interrupt line.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, conv_start, res_valid, inj_valid and all three interrupt outputs are low.
- R2: With cfg_res_long=1 the stored result equals conv_data. With cfg_res_long=0 it equals conv_data[9:2], zero-extended to 10 bits.
- R3: Mode 0 (one-shot, fixed channel): a rising edge of cfg_start while busy is low runs exactly one conversion of cfg_chan. busy then drops.
- R4: conv_chan never carries 8, 9, 10 or 11 when conv_start pulses. A programmed channel value in that range, normal or injected, is converted as channel 7.
- R5: Mode 2 (one-shot, group): the block converts every existing channel once, from cfg_chan down to 0, skipping 8 to 11. busy then drops.
- R6: Mode 1 repeats the fixed channel. Mode 3 restarts the group walk at cfg_chan after channel 0. Both keep going while cfg_start stays high.
- R7: In modes 1 and 3, clearing cfg_start lets a conversion already in progress finish. No further normal conversion starts, and busy drops.
- R8: With cfg_wait_read=1, no normal conversion starts while res_valid is high and res_read is low.
- R9: A result written into a register that still holds an unread result gives a one-cycle irq_err pulse, and the new result is still stored. For the normal register this applies only when cfg_wait_read is 0; for the injected register it applies always. A read strobe clears the valid flag.
- R10: inj_trig with cfg_inj_en=1 converts cfg_inj_chan as soon as no conversion is in progress, ahead of the next group channel. Its result and channel go to inj_data and inj_chan, and the group resumes at the interrupted channel. With cfg_inj_en=0 the trigger has no effect.
- R11: irq_eoc pulses for one cycle for each normal result, and irq_inj for each injected result. Either pulse comes the cycle after the conv_done that produced it.
- R12: conv_start is a one-cycle pulse, and no new start is issued while a conversion awaits conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start level; rising edge begins a sequence, low stops continuous modes |
| cfg_mode | input | 2 | bit0 continuous, bit1 group walk |
| cfg_chan | input | 4 | Fixed channel or highest channel of the group |
| cfg_res_long | input | 1 | 1 = 10-bit result, 0 = 8-bit result |
| cfg_wait_read | input | 1 | Hold normal conversions until the result is read |
| cfg_inj_en | input | 1 | Enable the injection trigger |
| cfg_inj_chan | input | 4 | Channel converted on injection |
| inj_trig | input | 1 | Injection trigger pulse |
| res_read | input | 1 | Read strobe for the normal result |
| inj_read | input | 1 | Read strobe for the injected result |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 4 | Multiplexer select |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter sample, valid with conv_done |
| busy | output | 1 | A normal sequence is active |
| res_data | output | 10 | Normal result |
| res_chan | output | 4 | Channel of the normal result |
| res_valid | output | 1 | Normal result unread |
| inj_data | output | 10 | Injected result |
| inj_chan | output | 4 | Channel of the injected result |
| inj_valid | output | 1 | Injected result unread |
| irq_eoc | output | 1 | Normal end-of-conversion pulse |
| irq_inj | output | 1 | Injected end-of-conversion pulse |
| irq_err | output | 1 | Overwrite error pulse |

## Verification
The hardest case to reach from the ports is an injection landing in the middle of a group walk. The trigger has to arrive while one group conversion is in progress, so that it is served before the next group channel and the walk must resume afterwards. The bench watches its own log of start pulses and fires the trigger in the cycle after the third group start. It then expects the injected channel at exactly the fourth log position, with the remaining group channels in their unbroken downward order. Held conversions in wait-for-read mode are reached by leaving the read strobe low for a long window and then giving a single read pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 4;
  localparam int MODE_CONT_BIT = 0;
  localparam int MODE_SCAN_BIT = 1;
  localparam logic [CH_W-1:0] CH_BELOW_GAP = 4'd7;
  localparam logic [CH_W-1:0] CH_ABOVE_GAP = 4'd12;

  // channels 8..11 have no input behind them
  function automatic logic chan_exists(input logic [CH_W-1:0] c);
    return c[3:2] != 2'b10;
  endfunction

  function automatic logic [CH_W-1:0] chan_clamp(input logic [CH_W-1:0] c);
    return chan_exists(c) ? c : CH_BELOW_GAP;
  endfunction

  function automatic logic [CH_W-1:0] chan_step_down(input logic [CH_W-1:0] c);
    return (c == CH_ABOVE_GAP) ? CH_BELOW_GAP : c - 1'b1;
  endfunction
endpackage

// File: rtl/adc_chan_sel.sv
module adc_chan_sel
  import adc_seq_pkg::*;
(
  input  logic            scan,
  input  logic [CH_W-1:0] prog_ch,
  input  logic [CH_W-1:0] cur_ch,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] step_ch,
  output logic            wrap
);
  always_comb begin
    first_ch = chan_clamp(prog_ch);
    step_ch  = scan ? chan_step_down(cur_ch) : cur_ch;
    wrap     = !scan || (cur_ch == '0);
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DW = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] wr_chan,
  input  logic          rd,
  input  logic          hold,
  output logic [DW-1:0] data,
  output logic [CW-1:0] chan,
  output logic          valid,
  output logic          ovr
);
  assign ovr = wr && valid && !rd && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      chan  <= '0;
      valid <= 1'b0;
    end else if (wr) begin
      data  <= wr_data;
      chan  <= wr_chan;
      valid <= 1'b1;
    end else if (rd) begin
      valid <= 1'b0;
    end
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !valid);
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (valid && chan == $past(wr_chan) && data == $past(wr_data)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_res_long,
  input  logic              cfg_wait_read,
  input  logic              cfg_inj_en,
  input  logic [CH_W-1:0]   cfg_inj_chan,
  input  logic              inj_trig,
  input  logic              res_read,
  input  logic              inj_read,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              res_valid,
  output logic [DATA_W-1:0] inj_data,
  output logic [CH_W-1:0]   inj_chan,
  output logic              inj_valid,
  output logic              irq_eoc,
  output logic              irq_inj,
  output logic              irq_err
);
  localparam int DROP_W = DATA_W - SHORT_W;

  typedef enum logic {S_IDLE, S_CONV} state_e;

  function automatic logic [DATA_W-1:0] fmt_result(input logic [DATA_W-1:0] d,
                                                   input logic long_mode);
    return long_mode ? d : (d >> DROP_W);
  endfunction

  state_e          state;
  logic            start_q, active, cur_inj, inj_pend, run_wait;
  logic [1:0]      run_mode;
  logic [CH_W-1:0] nxt_ch, cur_ch;
  logic [CH_W-1:0] first_ch, step_ch;
  logic            wrap;
  logic            ovr_n, ovr_i;

  // named internal events
  wire start_rise  = cfg_start && !start_q;
  wire run_cont    = run_mode[MODE_CONT_BIT];
  wire res_free    = !res_valid || res_read;
  wire launch_inj  = (state == S_IDLE) && inj_pend;
  wire launch_norm = (state == S_IDLE) && !inj_pend && active &&
                     (cfg_start || !run_cont) && (!cfg_wait_read || res_free);
  wire stop_idle   = (state == S_IDLE) && active && run_cont && !cfg_start;
  wire done_norm   = (state == S_CONV) && conv_done && !cur_inj;
  wire done_inj    = (state == S_CONV) && conv_done && cur_inj;
  wire seq_more    = run_cont ? cfg_start : !wrap;
  wire [DATA_W-1:0] fmt_data = fmt_result(conv_data, cfg_res_long);

  adc_chan_sel u_sel (
    .scan     (run_mode[MODE_SCAN_BIT]),
    .prog_ch  (cfg_chan),
    .cur_ch   (cur_ch),
    .first_ch (first_ch),
    .step_ch  (step_ch),
    .wrap     (wrap)
  );

  adc_result_reg #(.DW(DATA_W), .CW(CH_W)) u_res_norm (
    .clk (clk), .rst_n (rst_n), .wr (done_norm), .wr_data (fmt_data),
    .wr_chan (cur_ch), .rd (res_read), .hold (run_wait),
    .data (res_data), .chan (res_chan), .valid (res_valid), .ovr (ovr_n)
  );

  adc_result_reg #(.DW(DATA_W), .CW(CH_W)) u_res_inj (
    .clk (clk), .rst_n (rst_n), .wr (done_inj), .wr_data (fmt_data),
    .wr_chan (cur_ch), .rd (inj_read), .hold (1'b0),
    .data (inj_data), .chan (inj_chan), .valid (inj_valid), .ovr (ovr_i)
  );

  assign busy = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      start_q    <= 1'b0;
      active     <= 1'b0;
      cur_inj    <= 1'b0;
      inj_pend   <= 1'b0;
      run_wait   <= 1'b0;
      run_mode   <= '0;
      nxt_ch     <= '0;
      cur_ch     <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      irq_eoc    <= 1'b0;
      irq_inj    <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      start_q    <= cfg_start;
      conv_start <= 1'b0;
      irq_eoc    <= done_norm;
      irq_inj    <= done_inj;
      irq_err    <= ovr_n || ovr_i;

      if (launch_inj) inj_pend <= 1'b0;
      if (cfg_inj_en && inj_trig) inj_pend <= 1'b1;

      if (!active && start_rise) begin
        active   <= 1'b1;
        run_mode <= cfg_mode;
        nxt_ch   <= first_ch;
      end

      if (launch_inj) begin
        conv_start <= 1'b1;
        conv_chan  <= chan_clamp(cfg_inj_chan);
        cur_ch     <= chan_clamp(cfg_inj_chan);
        cur_inj    <= 1'b1;
        state      <= S_CONV;
      end else if (launch_norm) begin
        conv_start <= 1'b1;
        conv_chan  <= nxt_ch;
        cur_ch     <= nxt_ch;
        cur_inj    <= 1'b0;
        run_wait   <= cfg_wait_read;
        state      <= S_CONV;
      end else if (stop_idle) begin
        active <= 1'b0;
      end

      if (state == S_CONV && conv_done) begin
        state <= S_IDLE;
        if (!cur_inj) begin
          if (seq_more) nxt_ch <= wrap ? first_ch : step_ch;
          else          active <= 1'b0;
        end
      end
    end
  end

  a_r4_chan_exists: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> chan_exists(conv_chan));
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && !conv_done) |=> !conv_start);
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_norm && run_wait) |-> !res_valid);
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(res_valid || inj_valid));
  a_r11_eoc_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eoc || irq_inj) |-> $past(conv_done));
  a_r11_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_eoc && irq_inj));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_start = 0, cfg_res_long = 0, cfg_wait_read = 0, cfg_inj_en = 0;
  logic [1:0] cfg_mode = 0;
  logic [3:0] cfg_chan = 0, cfg_inj_chan = 0;
  logic       inj_trig = 0, inj_read = 0, rd_man = 0, auto_rd = 0;
  logic       res_read;
  logic       conv_start, conv_done = 0;
  logic [3:0] conv_chan;
  logic [9:0] conv_data = 0;
  logic       busy, res_valid, inj_valid, irq_eoc, irq_inj, irq_err;
  logic [9:0] res_data, inj_data;
  logic [3:0] res_chan, inj_chan;

  assign res_read = rd_man || (auto_rd && res_valid);

  always #10 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk (clk), .rst_n (rst_n), .cfg_start (cfg_start), .cfg_mode (cfg_mode),
    .cfg_chan (cfg_chan), .cfg_res_long (cfg_res_long), .cfg_wait_read (cfg_wait_read),
    .cfg_inj_en (cfg_inj_en), .cfg_inj_chan (cfg_inj_chan), .inj_trig (inj_trig),
    .res_read (res_read), .inj_read (inj_read), .conv_start (conv_start),
    .conv_chan (conv_chan), .conv_done (conv_done), .conv_data (conv_data),
    .busy (busy), .res_data (res_data), .res_chan (res_chan), .res_valid (res_valid),
    .inj_data (inj_data), .inj_chan (inj_chan), .inj_valid (inj_valid),
    .irq_eoc (irq_eoc), .irq_inj (irq_inj), .irq_err (irq_err)
  );

  // converter model and event logs
  int   mcnt = 0, seqn = 0;
  logic [3:0] m_chan = 0;
  int   log_ch[256];
  int   log_n = 0, eoc_n = 0, inj_n = 0, err_n = 0;
  logic [9:0] last_data = 0, last_inj_data = 0;
  int   n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) mcnt <= 0;
    else if (conv_start) begin
      mcnt   <= LAT;
      m_chan <= conv_chan;
      if (log_n < 256) log_ch[log_n] <= int'(conv_chan);
      log_n <= log_n + 1;
    end else if (mcnt != 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) begin
        conv_done <= 1'b1;
        conv_data <= {m_chan, 6'(seqn * 7 + 5)};
        seqn      <= seqn + 1;
      end
    end
    if (conv_done && m_chan == cfg_inj_chan && cfg_inj_en) last_inj_data <= conv_data;
    else if (conv_done) last_data <= conv_data;
    if (irq_eoc) eoc_n <= eoc_n + 1;
    if (irq_inj) inj_n <= inj_n + 1;
    if (irq_err) err_n <= err_n + 1;
  end

  function automatic int clamp(int c);
    return (c >= 8 && c <= 11) ? 7 : c;
  endfunction
  function automatic int scan_len(int top);
    int n = 0;
    for (int c = clamp(top); c >= 0; c--) if (c < 8 || c > 11) n++;
    return n;
  endfunction
  function automatic int scan_at(int top, int idx);
    int n = 0;
    for (int c = clamp(top); c >= 0; c--)
      if (c < 8 || c > 11) begin
        if (n == idx) return c;
        n++;
      end
    return -1;
  endfunction
  function automatic int fmt(logic [9:0] d, logic long_mode);
    return long_mode ? int'(d) : int'(d >> 2);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; cfg_start = 0; cfg_mode = 0; cfg_chan = 0; cfg_res_long = 1;
    cfg_wait_read = 0; cfg_inj_en = 0; cfg_inj_chan = 0; inj_trig = 0;
    inj_read = 0; rd_man = 0; auto_rd = 0;
    tick(3);
    rst_n = 1;
    log_n = 0; eoc_n = 0; inj_n = 0; err_n = 0;
    tick(1);
  endtask

  task automatic wait_idle(int lim);
    int k = 0;
    while ((busy || mcnt != 0 || conv_start || conv_done) && k < lim) begin
      tick(1); k++;
    end
    check(k < lim, "idle timeout", k, lim);
    tick(3);
  endtask

  task automatic run_seq(logic [1:0] md, logic [3:0] ch);
    cfg_mode = md; cfg_chan = ch; cfg_start = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    reset_dut();
    // R1 reset state
    check(!busy && !conv_start && !res_valid && !inj_valid, "R1 reset outputs", int'(busy), 0);
    check(!irq_eoc && !irq_inj && !irq_err, "R1 reset irqs", int'(irq_eoc), 0);

    // R3 and R2 long
    reset_dut(); cfg_res_long = 1; run_seq(2'd0, 4'd5); tick(1); wait_idle(200);
    check(log_n == 1, "R3 single count", log_n, 1);
    check(log_ch[0] == 5, "R3 single chan", log_ch[0], 5);
    check(!busy, "R3 busy clears", int'(busy), 0);
    check(res_chan == 5, "R3 result chan", int'(res_chan), 5);
    check(int'(res_data) == fmt(last_data, 1'b1), "R2 long data", int'(res_data), fmt(last_data, 1'b1));
    check(eoc_n == 1, "R11 eoc count", eoc_n, 1);
    cfg_start = 0;

    // R2 short, R4 invalid programmed channel
    reset_dut(); cfg_res_long = 0; run_seq(2'd0, 4'd10); tick(1); wait_idle(200);
    check(log_ch[0] == 7, "R4 gap channel to 7", log_ch[0], 7);
    check(int'(res_data) == fmt(last_data, 1'b0), "R2 short data", int'(res_data), fmt(last_data, 1'b0));

    // R5 scan single from 14
    reset_dut(); auto_rd = 1; run_seq(2'd2, 4'd14); tick(1); wait_idle(400);
    check(log_n == 11, "R5 scan count", log_n, 11);
    for (int i = 0; i < 11; i++)
      check(log_ch[i] == scan_at(14, i), "R5 scan order", log_ch[i], scan_at(14, i));
    check(!busy && res_chan == 0, "R5 ends at 0", int'(res_chan), 0);

    // R6 R7 fixed continuous with reads
    reset_dut(); auto_rd = 1; run_seq(2'd1, 4'd3); tick(40);
    cfg_start = 0; wait_idle(200);
    check(log_n >= 3, "R6 fixed repeats", log_n, 3);
    for (int i = 0; i < log_n && i < 256; i++) check(log_ch[i] == 3, "R6 fixed chan", log_ch[i], 3);
    check(!busy, "R7 stop clears busy", int'(busy), 0);
    check(err_n == 0, "R9 no error when read", err_n, 0);

    // R6 scan continuous wraps
    reset_dut(); auto_rd = 1; run_seq(2'd3, 4'd2);
    for (int k = 0; k < 400 && log_n < 7; k++) tick(1);
    cfg_start = 0; wait_idle(200);
    for (int i = 0; i < 7; i++) check(log_ch[i] == scan_at(2, i % 3), "R6 scan wrap", log_ch[i], scan_at(2, i % 3));

    // R8 wait for read
    reset_dut(); cfg_wait_read = 1; run_seq(2'd1, 4'd6); tick(60);
    check(log_n == 1, "R8 held without read", log_n, 1);
    rd_man = 1; tick(1); rd_man = 0; tick(20);
    check(log_n == 2, "R8 one more after read", log_n, 2);
    cfg_start = 0; tick(3);
    check(!busy, "R7 stop while held", int'(busy), 0);
    check(err_n == 0, "R9 no error in wait mode", err_n, 0);

    // R9 overwrite error
    reset_dut(); run_seq(2'd1, 4'd1);
    for (int k = 0; k < 400 && eoc_n < 2; k++) tick(1);
    tick(2);
    check(err_n >= 1, "R9 error raised", err_n, 1);
    cfg_start = 0; wait_idle(200);
    check(int'(res_data) == fmt(last_data, 1'b1) && res_chan == 1, "R9 still written", int'(res_data), fmt(last_data, 1'b1));

    // R10 injection into scan
    reset_dut(); auto_rd = 1; cfg_inj_en = 1; cfg_inj_chan = 13; run_seq(2'd2, 4'd7);
    for (int k = 0; k < 400 && log_n < 3; k++) tick(1);
    inj_trig = 1; tick(1); inj_trig = 0;
    wait_idle(400);
    check(log_n == 9 && log_ch[3] == 13, "R10 injected position", log_ch[3], 13);
    begin
      int j = 0;
      for (int i = 0; i < log_n && i < 256; i++)
        if (i != 3) begin
          check(log_ch[i] == scan_at(7, j), "R10 scan resumes", log_ch[i], scan_at(7, j));
          j++;
        end
    end
    check(inj_chan == 13 && inj_data == last_inj_data, "R10 inj register", int'(inj_data), int'(last_inj_data));
    check(eoc_n == 8 && inj_n == 1, "R11 separate irqs", inj_n, 1);

    // R10 trigger ignored when disabled
    reset_dut(); cfg_inj_en = 0; cfg_inj_chan = 13; run_seq(2'd0, 4'd2);
    tick(2); inj_trig = 1; tick(1); inj_trig = 0; wait_idle(200);
    check(log_n == 1 && log_ch[0] == 2, "R10 disabled no conv", log_n, 1);
    check(inj_n == 0 && !inj_valid, "R10 disabled no result", inj_n, 0);

    // R10 injection while idle, invalid channel clamps (R4)
    reset_dut(); cfg_inj_en = 1; cfg_inj_chan = 9;
    inj_trig = 1; tick(1); inj_trig = 0; tick(2); wait_idle(200);
    check(log_n == 1 && log_ch[0] == 7, "R4 injected clamp", log_ch[0], 7);
    check(!busy && inj_valid && !res_valid, "R10 idle inject", int'(inj_valid), 1);

    // random one-shot runs
    for (int it = 0; it < 24; it++) begin
      logic [1:0] md;
      logic [3:0] ch;
      int exp_n;
      reset_dut();
      md = ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd0;
      ch = 4'($urandom_range(0, 15));
      cfg_res_long = 1'($urandom_range(0, 1));
      cfg_wait_read = 1'($urandom_range(0, 1));
      auto_rd = 1;
      run_seq(md, ch); tick(1); wait_idle(600); cfg_start = 0;
      exp_n = (md == 2'd0) ? 1 : scan_len(int'(ch));
      check(log_n == exp_n, "R5 random count", log_n, exp_n);
      for (int i = 0; i < log_n && i < 256; i++)
        check(!(log_ch[i] >= 8 && log_ch[i] <= 11), "R4 random chan", log_ch[i], 0);
      check(int'(res_data) == fmt(last_data, cfg_res_long), "R2 random data", int'(res_data), fmt(last_data, cfg_res_long));
    end

    // random continuous runs
    for (int it = 0; it < 6; it++) begin
      logic [1:0] md;
      logic [3:0] ch;
      reset_dut();
      md = ($urandom_range(0, 1) != 0) ? 2'd3 : 2'd1;
      ch = 4'($urandom_range(0, 15));
      auto_rd = 1; cfg_wait_read = 1'($urandom_range(0, 1));
      run_seq(md, ch); tick($urandom_range(30, 90));
      cfg_start = 0; wait_idle(300);
      check(!busy, "R7 random stop", int'(busy), 0);
      for (int i = 0; i < log_n && i < 256; i++) begin
        int e;
        e = (md == 2'd1) ? clamp(int'(ch)) : scan_at(int'(ch), i % scan_len(int'(ch)));
        check(log_ch[i] == e, "R6 random sequence", log_ch[i], e);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule